// File: doc/BRIEF.md
# Host-to-Core Receive Queue with Slave Data Request

This block carries words from an external host to a processor core. The host pushes words into a small ring of storage. Each word is marked as slave data or as master data, and the core pops the words in arrival order. A receive request signal is raised when slave data waits for the core. It feeds an interrupt output, gated by an interrupt enable bit, and a DMA request output, gated by a DMA channel enable bit.

The request is worked out from the word at the head of the queue. When that word is master data, the request stays low even though the queue still holds data. The core is expected to pop such a word by other means. Once a slave word reaches the head, the request comes back.

A hardware reset and a software reset both empty the queue and clear the request and the overflow status. A host push into a full queue is dropped and sets a sticky overflow bit. A core pop from an empty queue returns zero and changes nothing.

Top module: `host_rx_fifo`

## Requirements
- R1: While `rst` or `soft_rst` is high at a clock edge, the queue is emptied. After that edge `rx_req`, `rx_irq`, `rx_dma` and `overflow` are 0, and `core_data` is 0.
- R2: A host push of a slave word (`host_master`=0) into an empty queue makes `rx_req` read 1 after that clock edge.
- R3: Words leave in the order they were pushed. `core_data` shows the head word, and a `core_rd` edge removes it.
- R4: When core pops remove the last word, `rx_req` reads 0 after that edge.
- R5: `rx_req` is 1 exactly when the queue is not empty and the head word is tagged slave (tag 0). A master word (tag 1) at the head holds `rx_req` at 0.
- R6: `rx_irq` equals `rx_req` AND `irq_en`.
- R7: `rx_dma` equals `rx_req` AND `dma_en`.
- R8: The queue holds DEPTH words. A push into a full queue without a pop in the same cycle is dropped. That push sets `overflow`, which stays 1 until a reset.
- R9: A `core_rd` on an empty queue leaves the queue unchanged, and `core_data` reads 0 while the queue is empty.
- R10: A push and a pop in the same cycle on a full queue both take effect, and `overflow` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| soft_rst | input | 1 | Software reset, synchronous, active high, same effect as `rst` |
| host_wr | input | 1 | Host push strobe |
| host_data | input | DATA_W | Host word to push |
| host_master | input | 1 | Tag of the pushed word: 1 master, 0 slave |
| core_rd | input | 1 | Core pop strobe |
| core_data | output | DATA_W | Head word, or 0 when empty |
| irq_en | input | 1 | Receive interrupt enable |
| dma_en | input | 1 | DMA channel enable for receive requests |
| rx_req | output | 1 | Slave data waiting at the head |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma | output | 1 | Receive DMA request |
| overflow | output | 1 | Sticky flag for a dropped host push |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. With the shallow ring, fill, wrap-around and overflow come up every few cycles. The sweep runs several thousand cycles of mixed push, pop, tag and enable patterns. It compares every output each cycle with a queue model held in the bench. This covers pushes and pops in the same cycle on full and empty queues, master words reaching the head, and both reset inputs in the middle of a run.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        TAG_SLAVE  = 1'b0,
        TAG_MASTER = 1'b1
    } rx_tag_e;

    // advance a ring index that wraps at an arbitrary depth
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx + 1 == depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 6
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rx_tag_e           push_tag,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output rx_tag_e           head_tag,
    output logic              empty,
    output logic              push_drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_data [DEPTH];
    rx_tag_e           mem_tag  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  level;
    logic              full, do_pop, do_push;

    assign empty     = (level == '0);
    assign full      = (level == CNT_W'(DEPTH));
    assign do_pop    = pop && !empty;
    assign do_push   = push && (!full || do_pop);
    assign push_drop = push && full && !do_pop;
    assign head_data = mem_data[rd_ptr];
    assign head_tag  = mem_tag[rd_ptr];

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_tag[i]  <= TAG_SLAVE;
                mem_data[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem_data[wr_ptr] <= push_data;
                mem_tag[wr_ptr]  <= push_tag;
                wr_ptr <= PTR_W'(ring_next(32'(wr_ptr), DEPTH));
            end
            if (do_pop)
                rd_ptr <= PTR_W'(ring_next(32'(rd_ptr), DEPTH));
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (clr)
        level <= CNT_W'(DEPTH)) else $error("level above depth"); // R8
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (clr)
        (push && empty && !pop) |=> !empty) else $error("push lost"); // R2
    AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (clr)
        (pop && level == CNT_W'(1) && !push) |=> empty) else $error("not emptied"); // R4
    AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (clr)
        (push_drop) |=> $stable(wr_ptr) && $stable(rd_ptr)) else $error("drop moved pointers"); // R8
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (clr)
        (pop && empty && !push) |=> empty && $stable(rd_ptr)) else $error("empty pop moved"); // R9
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (clr)
        (push && pop && full) |=> full) else $error("swap on full lost a word"); // R10

endmodule

// File: rtl/rxq_flag.sv
module rxq_flag
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    empty,
    input  rx_tag_e head_tag,
    input  logic    irq_en,
    input  logic    dma_en,
    output logic    rx_req,
    output logic    rx_irq,
    output logic    rx_dma
);
    // request only for slave data sitting at the head
    assign rx_req = !empty && (head_tag == TAG_SLAVE);
    assign rx_irq = rx_req && irq_en;
    assign rx_dma = rx_req && dma_en;

    AST_REQ_AFTER_CLEAR: assert property (@(posedge clk)
        clr |=> !rx_req) else $error("request after reset"); // R1
    AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (clr)
        rx_req |-> !empty) else $error("request with empty queue"); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (clr)
        rx_irq |-> (irq_en && !empty)) else $error("irq ungated"); // R6
    AST_DMA_GATED: assert property (@(posedge clk) disable iff (clr)
        rx_dma |-> (dma_en && !empty)) else $error("dma ungated"); // R7

endmodule

// File: rtl/host_rx_fifo.sv
module host_rx_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_master,
    input  logic              core_rd,
    output logic [DATA_W-1:0] core_data,
    input  logic              irq_en,
    input  logic              dma_en,
    output logic              rx_req,
    output logic              rx_irq,
    output logic              rx_dma,
    output logic              overflow
);
    logic              clr, empty, push_drop;
    logic [DATA_W-1:0] head_data;
    rx_tag_e           head_tag, in_tag;

    assign clr    = rst || soft_rst;
    assign in_tag = host_master ? TAG_MASTER : TAG_SLAVE;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .clr       (clr),
        .push      (host_wr),
        .push_data (host_data),
        .push_tag  (in_tag),
        .pop       (core_rd),
        .head_data (head_data),
        .head_tag  (head_tag),
        .empty     (empty),
        .push_drop (push_drop)
    );

    rxq_flag u_flag (
        .clk      (clk),
        .clr      (clr),
        .empty    (empty),
        .head_tag (head_tag),
        .irq_en   (irq_en),
        .dma_en   (dma_en),
        .rx_req   (rx_req),
        .rx_irq   (rx_irq),
        .rx_dma   (rx_dma)
    );

    assign core_data = empty ? '0 : head_data;

    always_ff @(posedge clk) begin
        if (clr) overflow <= 1'b0;
        else     overflow <= overflow || push_drop;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (clr)
        overflow |=> overflow) else $error("overflow not sticky"); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        clr |=> !overflow && !rx_irq && !rx_dma && core_data == '0) else $error("reset state"); // R1

endmodule

// File: tb/test_host_rx_fifo.sv
module test_host_rx_fifo;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int DEP    = 4;

    logic          clk = 1'b0;
    logic          rst, soft_rst, host_wr, host_master, core_rd, irq_en, dma_en;
    logic [DW-1:0] host_data, core_data;
    logic          rx_req, rx_irq, rx_dma, overflow;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the queue
    logic [DW-1:0] m_data [DEP];
    logic          m_tag  [DEP];
    int            m_n   = 0;
    bit            m_ovf = 0;

    always #(PERIOD/2) clk = ~clk;

    host_rx_fifo #(.DATA_W(DW), .DEPTH(DEP)) i_host_rx_fifo (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .host_wr(host_wr), .host_data(host_data), .host_master(host_master),
        .core_rd(core_rd), .core_data(core_data),
        .irq_en(irq_en), .dma_en(dma_en),
        .rx_req(rx_req), .rx_irq(rx_irq), .rx_dma(rx_dma), .overflow(overflow)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string ph);
        bit req;
        req = (m_n > 0) && !m_tag[0];
        check({"R3 R9 data ", ph}, int'(core_data), (m_n > 0) ? int'(m_data[0]) : 0);
        check({"R2 R4 R5 req ", ph}, int'(rx_req), int'(req));
        check({"R6 irq ", ph}, int'(rx_irq), int'(req && irq_en));
        check({"R7 dma ", ph}, int'(rx_dma), int'(req && dma_en));
        check({"R8 R10 ovf ", ph}, int'(overflow), int'(m_ovf));
    endtask

    task automatic step(bit r, bit sr, bit wr, bit rd, bit mst, logic [DW-1:0] d,
                        bit ie, bit de, string ph);
        @(negedge clk);
        rst = r; soft_rst = sr; host_wr = wr; core_rd = rd;
        host_master = mst; host_data = d; irq_en = ie; dma_en = de;
        @(posedge clk);
        if (r || sr) begin
            m_n = 0; m_ovf = 0;
        end else begin
            bit popped = 0;
            if (rd && m_n > 0) begin
                for (int k = 0; k < DEP - 1; k++) begin
                    m_data[k] = m_data[k+1]; m_tag[k] = m_tag[k+1];
                end
                m_n--; popped = 1;
            end
            if (wr) begin
                if (m_n < DEP) begin
                    m_data[m_n] = d; m_tag[m_n] = mst; m_n++;
                end else m_ovf = 1;
            end
            if (popped) begin end
        end
        #(PERIOD/4);
        check_all(ph);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; soft_rst = 0; host_wr = 0; core_rd = 0;
        host_master = 0; host_data = '0; irq_en = 0; dma_en = 0;
        // R1 reset state
        step(1, 0, 0, 0, 0, 8'h00, 1, 1, "R1 reset");
        step(0, 0, 0, 0, 0, 8'h00, 1, 1, "R1 idle");
        // R9 pop from empty
        step(0, 0, 0, 1, 0, 8'h00, 1, 1, "R9 empty pop");
        // R2 single slave push
        step(0, 0, 1, 0, 0, 8'h5A, 1, 1, "R2 push");
        // R4 drain
        step(0, 0, 0, 1, 0, 8'h00, 1, 1, "R4 drain");
        // R5 master head suppresses request, slave behind it
        step(0, 0, 1, 0, 1, 8'hA1, 1, 1, "R5 master");
        step(0, 0, 1, 0, 0, 8'hA2, 1, 1, "R5 slave behind");
        step(0, 0, 0, 1, 0, 8'h00, 1, 0, "R5 master popped");
        step(0, 0, 0, 1, 0, 8'h00, 0, 1, "R5 empty");
        // R8 fill, overflow, R10 swap on full
        for (int k = 0; k < DEP; k++)
            step(0, 0, 1, 0, 0, DW'(k + 16), 1, 1, "R8 fill");
        step(0, 0, 1, 1, 0, 8'h77, 1, 1, "R10 swap full");
        step(0, 0, 1, 0, 0, 8'h66, 1, 1, "R8 overflow");
        step(0, 0, 0, 0, 0, 8'h00, 1, 1, "R8 sticky");
        // R1 software reset
        step(0, 1, 0, 0, 0, 8'h00, 1, 1, "R1 soft reset");
        // sweep: mixed push/pop/tag/enable patterns with several fill biases
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                int  wth = 2 + ph;
                bit  wr  = ((i * 7 + 3) % 6) < wth;
                bit  rd  = ((i * 5 + ph) % 6) < (5 - ph);
                bit  mst = ((i * 3 + ph) % 7) == 0;
                bit  sr  = (i % 397) == 396;
                step(0, sr, wr, rd, mst, DW'(i * 13 + ph), i[2], i[4], "sweep");
            end
        end
        step(1, 0, 0, 0, 0, 8'h00, 1, 1, "R1 final reset");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule